// File: doc/BRIEF.md
# Integer Add/Subtract Unit with Overflow Trap

This block is the integer adder stage of a simple processor datapath. Each cycle it takes a 3-bit opcode, two 32-bit register operands, a 16-bit immediate, the address of the current instruction and a valid strobe. From these it produces a 32-bit result and a write-enable for the destination register in the same cycle. Eight operations share one carry-propagate adder: signed and unsigned add, signed and unsigned subtract, signed and unsigned add-immediate, and signed and unsigned set-less-than. Subtraction and comparison feed the adder the inverted second operand with a carry-in of one.

Only the signed add, subtract and add-immediate operations check for two's-complement overflow. When one of them overflows, the unit raises a trap request in the same cycle and withholds the write-enable, so the wrapped value is not committed. It also drives a fixed redirect address for the fetch logic. On the next clock edge it latches the faulting instruction's address into an exception-address register. The unsigned forms wrap modulo 2^32 and never trap. The unsigned add-immediate still sign-extends its immediate.

Top module: `int_alu_top`

## Requirements
- R1: Opcodes are 000 add, 001 add-unsigned, 010 subtract, 011 subtract-unsigned, 100 add-immediate, 101 add-immediate-unsigned, 110 set-less-than, 111 set-less-than-unsigned. Add and subtract results equal opA+opB and opA-opB modulo 2^32, for both the signed and the unsigned form.
- R2: Both immediate forms add opA to the immediate extended to 32 bits by copying immediate bit 15 into bits 31..16. This holds for the unsigned immediate form as well.
- R3: Signed add and signed add-immediate raise trapReq exactly when both addends have the same sign bit and the sum's sign bit differs from it. Addends of opposite sign never trap.
- R4: Signed subtract raises trapReq exactly when the operands' sign bits differ and the difference's sign bit differs from opA's sign bit.
- R5: Add-unsigned, subtract-unsigned and add-immediate-unsigned never raise trapReq, whatever the operands.
- R6: Signed set-less-than returns 1 when opA < opB as signed numbers and 0 otherwise, with bits 31..1 zero. Neither compare form ever traps.
- R7: Unsigned set-less-than returns 1 when opA < opB as unsigned magnitudes and 0 otherwise.
- R8: With instValid high, writeEn is the inverse of trapReq.
- R9: excAddr loads instAddr on a rising edge where trapReq is high and holds on every other edge. A synchronous reset clears it to 0.
- R10: vectorAddr equals the VECTOR_ADDR parameter (default 0x00000100) while trapReq is high and is 0 otherwise.
- R11: With instValid low, writeEn and trapReq stay low and excAddr does not change, even for operands that would overflow.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| instValid | input | 1 | An instruction is presented this cycle |
| opcode | input | 3 | Operation select |
| opA | input | 32 | First register operand |
| opB | input | 32 | Second register operand |
| imm | input | 16 | Immediate field |
| instAddr | input | 32 | Address of the presented instruction |
| result | output | 32 | Arithmetic or compare result |
| writeEn | output | 1 | Commit result to the destination register |
| trapReq | output | 1 | Signed overflow trap request |
| vectorAddr | output | 32 | Fetch redirect address during a trap |
| excAddr | output | 32 | Address of the last faulting instruction |

## Verification
The directed operands sit on the sign boundaries: 0x7FFFFFFF, 0x80000000, 0, 1 and -1. Same-sign and opposite-sign pairs at these values separate true overflow from the cases that only look risky, and running one pair under the signed and the unsigned opcode shows that only the signed form traps. Immediates with bit 15 set tell sign extension apart from zero extension. Compares of -1 against 1 give opposite answers in the signed and unsigned forms. Random operands, about a quarter of them drawn from the boundary set, are mixed with invalid cycles to check that excAddr holds except on trapping edges.

// File: rtl/arith_pkg.sv
package arith_pkg;

  typedef enum logic [2:0] {
    OP_ADD   = 3'b000,
    OP_ADDU  = 3'b001,
    OP_SUB   = 3'b010,
    OP_SUBU  = 3'b011,
    OP_ADDI  = 3'b100,
    OP_ADDIU = 3'b101,
    OP_SLT   = 3'b110,
    OP_SLTU  = 3'b111
  } opcode_e;

  // strobes from control to datapath
  typedef struct packed {
    logic invertB;      // subtract: ~B with carry-in 1
    logic useImm;       // second operand from extended immediate
    logic trapEn;       // signed form, overflow may trap
    logic selCompare;   // result is the less-than flag
    logic cmpUnsigned;  // compare magnitudes
  } ctrl_strobes_t;

endpackage

// File: rtl/alu_ctrl.sv
module alu_ctrl
  import arith_pkg::*;
(
  input  logic [2:0]    opcode,
  output ctrl_strobes_t strobes
);

  opcode_e op;
  assign op = opcode_e'(opcode);

  always_comb begin
    strobes = '0;
    unique case (op)
      OP_ADD:   strobes.trapEn = 1'b1;
      OP_ADDU:  ;
      OP_SUB: begin
        strobes.invertB = 1'b1;
        strobes.trapEn  = 1'b1;
      end
      OP_SUBU:  strobes.invertB = 1'b1;
      OP_ADDI: begin
        strobes.useImm = 1'b1;
        strobes.trapEn = 1'b1;
      end
      OP_ADDIU: strobes.useImm = 1'b1;
      OP_SLT: begin
        strobes.invertB    = 1'b1;
        strobes.selCompare = 1'b1;
      end
      OP_SLTU: begin
        strobes.invertB     = 1'b1;
        strobes.selCompare  = 1'b1;
        strobes.cmpUnsigned = 1'b1;
      end
      default: strobes = '0;
    endcase
  end

endmodule

// File: rtl/alu_datapath.sv
module alu_datapath
  import arith_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int IMM_W  = 16
) (
  input  ctrl_strobes_t       strobes,
  input  logic [DATA_W-1:0]   opA,
  input  logic [DATA_W-1:0]   opB,
  input  logic [IMM_W-1:0]    imm,
  output logic [DATA_W-1:0]   result,
  output logic                overflow
);

  localparam int EXT_W = DATA_W - IMM_W;
  localparam int MSB   = DATA_W - 1;

  logic [DATA_W-1:0] immExt;
  logic [DATA_W-1:0] operandB;
  logic [DATA_W-1:0] bEff;
  logic [DATA_W:0]   sumFull;
  logic [DATA_W-1:0] sum;
  logic              carryOut;
  logic              ovfRaw;
  logic              lessThan;

  generate
    if (EXT_W > 0) begin : g_sext
      assign immExt = {{EXT_W{imm[IMM_W-1]}}, imm};
    end else begin : g_trunc
      assign immExt = imm[DATA_W-1:0];
    end
  endgenerate

  assign operandB = strobes.useImm  ? immExt : opB;
  assign bEff     = strobes.invertB ? ~operandB : operandB;

  assign sumFull  = {1'b0, opA} + {1'b0, bEff} + {{DATA_W{1'b0}}, strobes.invertB};
  assign sum      = sumFull[DATA_W-1:0];
  assign carryOut = sumFull[DATA_W];

  // same-sign inputs to the adder producing a flipped sign
  assign ovfRaw   = (opA[MSB] == bEff[MSB]) && (sum[MSB] != opA[MSB]);

  // signed: sign of difference corrected by overflow; unsigned: borrow
  assign lessThan = strobes.cmpUnsigned ? ~carryOut : (sum[MSB] ^ ovfRaw);

  assign result   = strobes.selCompare ? {{(DATA_W-1){1'b0}}, lessThan} : sum;
  assign overflow = ovfRaw & strobes.trapEn;

endmodule

// File: rtl/exc_capture.sv
module exc_capture #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] addrIn,
  output logic [ADDR_W-1:0] addrOut
);

  always_ff @(posedge clk) begin
    if (rst)       addrOut <= '0;
    else if (load) addrOut <= addrIn;
  end

endmodule

// File: rtl/int_alu_top.sv
module int_alu_top
  import arith_pkg::*;
#(
  parameter int               DATA_W      = 32,
  parameter int               IMM_W       = 16,
  parameter int               ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] VECTOR_ADDR = 32'h0000_0100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              instValid,
  input  logic [2:0]        opcode,
  input  logic [DATA_W-1:0] opA,
  input  logic [DATA_W-1:0] opB,
  input  logic [IMM_W-1:0]  imm,
  input  logic [ADDR_W-1:0] instAddr,
  output logic [DATA_W-1:0] result,
  output logic              writeEn,
  output logic              trapReq,
  output logic [ADDR_W-1:0] vectorAddr,
  output logic [ADDR_W-1:0] excAddr
);

  ctrl_strobes_t strobes;
  logic          overflow;

  alu_ctrl u_ctrl (
    .opcode  (opcode),
    .strobes (strobes)
  );

  alu_datapath #(
    .DATA_W (DATA_W),
    .IMM_W  (IMM_W)
  ) u_dp (
    .strobes  (strobes),
    .opA      (opA),
    .opB      (opB),
    .imm      (imm),
    .result   (result),
    .overflow (overflow)
  );

  assign trapReq    = instValid & overflow;
  assign writeEn    = instValid & ~trapReq;
  assign vectorAddr = trapReq ? VECTOR_ADDR : '0;

  exc_capture #(
    .ADDR_W (ADDR_W)
  ) u_exc (
    .clk     (clk),
    .rst     (rst),
    .load    (trapReq),
    .addrIn  (instAddr),
    .addrOut (excAddr)
  );

endmodule

// File: rtl/int_alu_checker.sv
module int_alu_checker #(
  parameter int               DATA_W      = 32,
  parameter int               IMM_W       = 16,
  parameter int               ADDR_W      = 32,
  parameter logic [ADDR_W-1:0] VECTOR_ADDR = 32'h0000_0100
) (
  input logic              clk,
  input logic              rst,
  input logic              instValid,
  input logic [2:0]        opcode,
  input logic [DATA_W-1:0] opA,
  input logic [DATA_W-1:0] opB,
  input logic [IMM_W-1:0]  imm,
  input logic [ADDR_W-1:0] instAddr,
  input logic [DATA_W-1:0] result,
  input logic              writeEn,
  input logic              trapReq,
  input logic [ADDR_W-1:0] vectorAddr,
  input logic [ADDR_W-1:0] excAddr
);

  localparam int MSB = DATA_W - 1;

  assert_opposite_add_R3: assert property (@(posedge clk) disable iff (rst)
    (instValid && opcode == 3'b000 && opA[MSB] != opB[MSB]) |-> !trapReq);

  assert_same_sub_R4: assert property (@(posedge clk) disable iff (rst)
    (instValid && opcode == 3'b010 && opA[MSB] == opB[MSB]) |-> !trapReq);

  assert_no_unsigned_trap_R5: assert property (@(posedge clk) disable iff (rst)
    (opcode inside {3'b001, 3'b011, 3'b101}) |-> !trapReq);

  assert_compare_shape_R6: assert property (@(posedge clk) disable iff (rst)
    (instValid && opcode[2:1] == 2'b11) |-> (result[DATA_W-1:1] == '0 && !trapReq));

  assert_trap_blocks_write_R8: assert property (@(posedge clk) disable iff (rst)
    instValid |-> (writeEn != trapReq));

  assert_capture_R9: assert property (@(posedge clk) disable iff (rst)
    trapReq |=> (excAddr == $past(instAddr)));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    !trapReq |=> $stable(excAddr));

  assert_vector_R10: assert property (@(posedge clk) disable iff (rst)
    trapReq ? (vectorAddr == VECTOR_ADDR) : (vectorAddr == '0));

  assert_idle_R11: assert property (@(posedge clk) disable iff (rst)
    !instValid |-> (!writeEn && !trapReq));

endmodule

bind int_alu_top int_alu_checker #(
  .DATA_W      (DATA_W),
  .IMM_W       (IMM_W),
  .ADDR_W      (ADDR_W),
  .VECTOR_ADDR (VECTOR_ADDR)
) u_chk (
  .clk        (clk),
  .rst        (rst),
  .instValid  (instValid),
  .opcode     (opcode),
  .opA        (opA),
  .opB        (opB),
  .imm        (imm),
  .instAddr   (instAddr),
  .result     (result),
  .writeEn    (writeEn),
  .trapReq    (trapReq),
  .vectorAddr (vectorAddr),
  .excAddr    (excAddr)
);

// File: tb/int_alu_top_tb.sv
module int_alu_top_tb;

  localparam logic [31:0] VEC = 32'h0000_0100;

  logic        clk = 1'b0;
  logic        rst;
  logic        instValid;
  logic [2:0]  opcode;
  logic [31:0] opA, opB, instAddr;
  logic [15:0] imm;
  logic [31:0] result, vectorAddr, excAddr;
  logic        writeEn, trapReq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  logic [31:0] modelExc = '0;

  always #5 clk = ~clk;
  always @(posedge clk) cycles++;

  int_alu_top #(.VECTOR_ADDR(VEC)) u_dut (
    .clk(clk), .rst(rst), .instValid(instValid), .opcode(opcode),
    .opA(opA), .opB(opB), .imm(imm), .instAddr(instAddr),
    .result(result), .writeEn(writeEn), .trapReq(trapReq),
    .vectorAddr(vectorAddr), .excAddr(excAddr)
  );

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  function automatic logic [31:0] sext16(logic [15:0] i);
    return {{16{i[15]}}, i};
  endfunction

  // expected result and signed-overflow flag, from the requirements
  function automatic void model(input logic [2:0] op, input logic [31:0] a, b,
                                input logic [15:0] im,
                                output logic [31:0] res, output logic ovf);
    logic [31:0] x;
    ovf = 1'b0;
    case (op)
      3'b000, 3'b001, 3'b100, 3'b101: begin
        x   = (op[2]) ? sext16(im) : b;
        res = a + x;
        if (op == 3'b000 || op == 3'b100)
          ovf = (a[31] == x[31]) && (res[31] != a[31]);
      end
      3'b010, 3'b011: begin
        res = a - b;
        if (op == 3'b010) ovf = (a[31] != b[31]) && (res[31] != a[31]);
      end
      3'b110: res = ($signed(a) < $signed(b)) ? 32'd1 : 32'd0;
      default: res = (a < b) ? 32'd1 : 32'd0;
    endcase
  endfunction

  function automatic string resTag(logic [2:0] op);
    case (op)
      3'b100, 3'b101: return "R2";
      3'b110:         return "R6";
      3'b111:         return "R7";
      default:        return "R1";
    endcase
  endfunction

  function automatic string trapTag(logic [2:0] op);
    case (op)
      3'b000, 3'b100: return "R3";
      3'b010:         return "R4";
      3'b110, 3'b111: return "R6";
      default:        return "R5";
    endcase
  endfunction

  task automatic runOp(logic valid, logic [2:0] op, logic [31:0] a, b,
                       logic [15:0] im, logic [31:0] pc);
    logic [31:0] expRes;
    logic ovf, expTrap;
    @(negedge clk);
    instValid = valid; opcode = op; opA = a; opB = b; imm = im; instAddr = pc;
    #2;
    model(op, a, b, im, expRes, ovf);
    expTrap = valid && ovf;
    if (valid) check(resTag(op), "result", result, expRes);
    check(valid ? trapTag(op) : "R11", "trapReq", {31'd0, trapReq}, {31'd0, expTrap});
    check(valid ? "R8" : "R11", "writeEn", {31'd0, writeEn}, {31'd0, valid && !expTrap});
    check("R10", "vectorAddr", vectorAddr, expTrap ? VEC : 32'd0);
    @(posedge clk);
    #1;
    if (expTrap) modelExc = pc;
    check(valid ? "R9" : "R11", "excAddr", excAddr, modelExc);
  endtask

  function automatic logic [31:0] pick();
    logic [31:0] corners [5] = '{32'h7FFF_FFFF, 32'h8000_0000, 32'h0, 32'h1, 32'hFFFF_FFFF};
    if ($urandom_range(3) == 0) return corners[$urandom_range(4)];
    return $urandom;
  endfunction

  initial begin
    wait (cycles > 100000);
    failures++;
    $display("FAIL watchdog actual=%0d expected<100000", cycles);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1; instValid = 1'b0; opcode = '0; opA = '0; opB = '0; imm = '0; instAddr = '0;
    repeat (3) @(posedge clk);
    #1;
    check("R9", "excAddr after reset", excAddr, 32'd0);
    check("R11", "writeEn in reset idle", {31'd0, writeEn}, 32'd0);
    @(negedge clk);
    rst = 1'b0;

    // R3 signed add overflow corners
    runOp(1, 3'b000, 32'h7FFF_FFFF, 32'h1, 16'h0, 32'h0000_1000);
    runOp(1, 3'b000, 32'h8000_0000, 32'hFFFF_FFFF, 16'h0, 32'h0000_1004);
    runOp(1, 3'b000, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 32'h0000_1008);
    // R4 signed subtract
    runOp(1, 3'b010, 32'h7FFF_FFFF, 32'hFFFF_FFFF, 16'h0, 32'h0000_100C);
    runOp(1, 3'b010, 32'h8000_0000, 32'h1, 16'h0, 32'h0000_1010);
    runOp(1, 3'b010, 32'h8000_0000, 32'h8000_0000, 16'h0, 32'h0000_1014);
    // R5 unsigned forms wrap without trapping
    runOp(1, 3'b001, 32'h7FFF_FFFF, 32'h1, 16'h0, 32'h0000_1018);
    runOp(1, 3'b011, 32'h8000_0000, 32'h1, 16'h0, 32'h0000_101C);
    runOp(1, 3'b101, 32'h7FFF_FFFF, 32'h0, 16'h0001, 32'h0000_1020);
    // R2 sign extension, both immediate forms
    runOp(1, 3'b101, 32'h0001_0000, 32'h0, 16'h8000, 32'h0000_1024);
    runOp(1, 3'b100, 32'h0000_0005, 32'h0, 16'hFFFF, 32'h0000_1028);
    runOp(1, 3'b100, 32'h8000_0000, 32'h0, 16'hFFFF, 32'h0000_102C);
    // R6 / R7 compares
    runOp(1, 3'b110, 32'hFFFF_FFFF, 32'h1, 16'h0, 32'h0000_1030);
    runOp(1, 3'b111, 32'hFFFF_FFFF, 32'h1, 16'h0, 32'h0000_1034);
    runOp(1, 3'b110, 32'h7FFF_FFFF, 32'h8000_0000, 16'h0, 32'h0000_1038);
    runOp(1, 3'b111, 32'h5, 32'h5, 16'h0, 32'h0000_103C);
    // R11 invalid cycle with overflowing operands
    runOp(0, 3'b000, 32'h7FFF_FFFF, 32'h1, 16'h0, 32'h0000_2000);

    for (int i = 0; i < 400; i++) begin
      runOp(($urandom_range(7) != 0), 3'($urandom_range(7)), pick(), pick(),
            16'($urandom), 32'h0001_0000 + 32'(i * 4));
    end

    // R9 reset clears a captured address
    runOp(1, 3'b000, 32'h7FFF_FFFF, 32'h7FFF_FFFF, 16'h0, 32'h0000_3000);
    @(negedge clk);
    instValid = 1'b0;
    rst = 1'b1;
    @(posedge clk);
    #1;
    check("R9", "excAddr cleared by reset", excAddr, 32'd0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule